// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block tells the scheduler of an out-of-order core whether a memory instruction must wait behind an older store that is still in flight. It keeps two tables. The first table is indexed by instruction address and gives a store-set identifier. The second table is indexed by that identifier and holds the sequence number of the newest store of the set that has been fetched. Every entry in both tables has its own valid bit.

A memory-ordering violation between a store and a younger load joins both instructions into one set. A fetched store then records its sequence number against its set, and a lookup returns that number. Entries are dropped when the recorded store issues, when a squash removes younger work, or when a global clear runs. Lookups are combinational on the table state. Updates are written at the clock edge and are visible from the next cycle on.

Top module: `store_set_predictor`

## Requirements
- R1: The set-ID table index is `(pc >> OFFSET_BITS) & (SSIT_DEPTH-1)`. With the defaults (offset 2, 1024 entries) this is PC bits [11:2], so PCs that differ only above bit 11 share an entry.
- R2: A fresh set ID is `(pc ^ (pc >> 10)) mod LFST_DEPTH`, computed from the store PC. With 128 entries this is the low 7 bits of the fold.
- R3: A violation (store PC, load PC) writes one common ID to both PCs' set-ID entries and marks both valid. If neither PC holds a valid ID, both get the fresh ID of the store PC. If only one holds a valid ID, the other copies it. If both hold valid IDs, both take the numerically smaller one.
- R4: `look_dep_seq` returns the stored sequence number when the looked-up PC's set-ID entry is valid and the last-store entry for that ID is valid. Otherwise it returns 0. It is combinational on the state left by earlier clock edges.
- R5: A store insert writes its sequence number into the last-store entry of its set only when its set-ID entry is valid. An insert with sequence number 0 is ignored, because 0 is reserved to mean no dependence.
- R6: When a violation and an insert occur in the same cycle, the insert uses the set IDs as updated by that violation.
- R7: An issue of a store invalidates its set's last-store entry only if that entry holds exactly the issued sequence number. A load issue has no effect.
- R8: A squash with number N invalidates every last-store entry whose sequence number is greater than N, including an entry written by an insert in the same cycle. Entries at or below N stay valid.
- R9: `clr` invalidates every entry of both tables and overrides any other update in that cycle.
- R10: After reset every entry is invalid, so every lookup returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Invalidate both tables |
| viol_valid | input | 1 | Violation report valid |
| viol_store_pc | input | PC_W | PC of the older store in the violation |
| viol_load_pc | input | PC_W | PC of the younger load in the violation |
| ins_valid | input | 1 | Store insert valid |
| ins_pc | input | PC_W | PC of the inserted store |
| ins_seq | input | SEQ_W | Sequence number of the inserted store |
| look_pc | input | PC_W | PC to test for a dependence |
| look_dep_seq | output | SEQ_W | Sequence number of the predicted producer store, 0 if none |
| iss_valid | input | 1 | Issue notification valid |
| iss_is_store | input | 1 | The issued instruction is a store |
| iss_pc | input | PC_W | PC of the issued instruction |
| iss_seq | input | SEQ_W | Sequence number of the issued instruction |
| sq_valid | input | 1 | Squash request valid |
| sq_seq | input | SEQ_W | Squash boundary; younger stores are dropped |

## Verification
Every update (violation, insert, issue, squash, clear) changes state at one rising edge, and its effect on `look_dep_seq` is due in the cycle that follows. The lookup itself has no register on its path.

The bench therefore drives each operation at a falling edge and lets one rising edge pass. At the next falling edge it sets `look_pc` and compares `look_dep_seq` a short delay later, with no further edge in between. In the model-compare phase the expected lookup is taken from the model before that cycle's update is applied, since the check falls before the edge that commits the update.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   // How a violation resolves the identifiers of its two PCs.
   typedef enum logic [1:0] {
      MRG_FRESH      = 2'd0,
      MRG_TAKE_STORE = 2'd1,
      MRG_TAKE_LOAD  = 2'd2,
      MRG_TAKE_MIN   = 2'd3
   } merge_kind_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
   parameter int PC_W        = 32,
   parameter int DEPTH       = 1024,
   parameter int ID_W        = 7,
   parameter int OFFSET_BITS = 2,
   parameter int N_RD        = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          wr_en,
   input  logic [$clog2(DEPTH)-1:0]      wr_idx_a,
   input  logic [$clog2(DEPTH)-1:0]      wr_idx_b,
   input  logic [ID_W-1:0]               wr_id,
   input  logic [N_RD-1:0][PC_W-1:0]     rd_pc,
   output logic [N_RD-1:0]               rd_vld,
   output logic [N_RD-1:0][ID_W-1:0]     rd_id
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DEPTH-1:0] vld_q;
   logic [ID_W-1:0]  id_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (clr) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx_a] <= 1'b1;
         vld_q[wr_idx_b] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clr) begin
         id_q[wr_idx_a] <= wr_id;
         id_q[wr_idx_b] <= wr_id;
      end
   end

   for (genvar r = 0; r < N_RD; r++) begin : g_rd
      logic [IDX_W-1:0] idx;
      assign idx       = IDX_W'((rd_pc[r] >> OFFSET_BITS) & PC_W'(DEPTH - 1));
      assign rd_vld[r] = vld_q[idx];
      assign rd_id[r]  = id_q[idx];
   end

endmodule

// File: rtl/ssp_viol_merge.sv
module ssp_viol_merge
   import ssp_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int DEPTH      = 128,
   parameter int ID_W       = 7,
   parameter int HASH_SHIFT = 10
) (
   input  logic [PC_W-1:0] store_pc,
   input  logic            s_vld,
   input  logic [ID_W-1:0] s_id,
   input  logic            l_vld,
   input  logic [ID_W-1:0] l_id,
   output logic [ID_W-1:0] merged_id
);
   logic [PC_W-1:0] fold;
   logic [ID_W-1:0] fresh_id;
   merge_kind_e     kind;

   assign fold = store_pc ^ (store_pc >> HASH_SHIFT);

   if (is_pow2(DEPTH)) begin : g_hash_mask
      assign fresh_id = ID_W'(fold & PC_W'(DEPTH - 1));
   end else begin : g_hash_mod
      assign fresh_id = ID_W'(fold % PC_W'(DEPTH));
   end

   always_comb begin
      case ({s_vld, l_vld})
         2'b00:   kind = MRG_FRESH;
         2'b10:   kind = MRG_TAKE_STORE;
         2'b01:   kind = MRG_TAKE_LOAD;
         default: kind = MRG_TAKE_MIN;
      endcase
   end

   always_comb begin
      unique case (kind)
         MRG_FRESH:      merged_id = fresh_id;
         MRG_TAKE_STORE: merged_id = s_id;
         MRG_TAKE_LOAD:  merged_id = l_id;
         MRG_TAKE_MIN:   merged_id = (s_id < l_id) ? s_id : l_id;
         default:        merged_id = fresh_id;
      endcase
   end

endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst #(
   parameter int DEPTH = 128,
   parameter int ID_W  = 7,
   parameter int SEQ_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        ins_en,
   input  logic [ID_W-1:0]             ins_id,
   input  logic [SEQ_W-1:0]            ins_seq,
   input  logic                        iss_en,
   input  logic [ID_W-1:0]             iss_id,
   input  logic [SEQ_W-1:0]            iss_seq,
   input  logic                        sq_en,
   input  logic [SEQ_W-1:0]            sq_seq,
   input  logic [ID_W-1:0]             rd_id,
   output logic                        rd_vld,
   output logic [SEQ_W-1:0]            rd_seq,
   output logic [DEPTH-1:0]            ent_vld,
   output logic [DEPTH-1:0][SEQ_W-1:0] ent_seq
);
   logic [DEPTH-1:0]            vld_q, vld_d;
   logic [DEPTH-1:0][SEQ_W-1:0] seq_q;

   // Per entry: insert first, then issue match, then squash, clear over all.
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic             wr_hit;
      logic [SEQ_W-1:0] seq_after_ins;
      logic             kill_iss;
      logic             kill_sq;
      assign wr_hit        = ins_en && (ins_id == ID_W'(e));
      assign seq_after_ins = wr_hit ? ins_seq : seq_q[e];
      assign kill_iss      = iss_en && (iss_id == ID_W'(e)) && (seq_after_ins == iss_seq);
      assign kill_sq       = sq_en && (seq_after_ins > sq_seq);
      assign vld_d[e]      = !clr && (vld_q[e] || wr_hit) && !kill_iss && !kill_sq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         seq_q <= '0;
      end else begin
         vld_q <= vld_d;
         if (ins_en && !clr) begin
            seq_q[ins_id] <= ins_seq;
         end
      end
   end

   assign rd_vld  = vld_q[rd_id];
   assign rd_seq  = seq_q[rd_id];
   assign ent_vld = vld_q;
   assign ent_seq = seq_q;

endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor
   import ssp_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int SEQ_W       = 16,
   parameter int SSIT_DEPTH  = 1024,
   parameter int LFST_DEPTH  = 128,
   parameter int OFFSET_BITS = 2,
   parameter int HASH_SHIFT  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             viol_valid,
   input  logic [PC_W-1:0]  viol_store_pc,
   input  logic [PC_W-1:0]  viol_load_pc,
   input  logic             ins_valid,
   input  logic [PC_W-1:0]  ins_pc,
   input  logic [SEQ_W-1:0] ins_seq,
   input  logic [PC_W-1:0]  look_pc,
   output logic [SEQ_W-1:0] look_dep_seq,
   input  logic             iss_valid,
   input  logic             iss_is_store,
   input  logic [PC_W-1:0]  iss_pc,
   input  logic [SEQ_W-1:0] iss_seq,
   input  logic             sq_valid,
   input  logic [SEQ_W-1:0] sq_seq
);
   localparam int IDX_W   = $clog2(SSIT_DEPTH);
   localparam int ID_W    = (LFST_DEPTH > 1) ? $clog2(LFST_DEPTH) : 1;
   localparam int N_RD    = 5;
   localparam int RD_VS   = 0;
   localparam int RD_VL   = 1;
   localparam int RD_INS  = 2;
   localparam int RD_ISS  = 3;
   localparam int RD_LOOK = 4;

   if (!is_pow2(SSIT_DEPTH)) begin : g_bad_ssit_depth
      $error("SSIT_DEPTH must be a power of two");
   end
   if (LFST_DEPTH < 2) begin : g_bad_lfst_depth
      $error("LFST_DEPTH must be at least 2");
   end
   if (IDX_W + OFFSET_BITS > PC_W) begin : g_bad_pc_width
      $error("PC_W too narrow for index and offset");
   end
   if (SEQ_W < 2) begin : g_bad_seq_width
      $error("SEQ_W must be at least 2");
   end

   function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
      return IDX_W'((pc >> OFFSET_BITS) & PC_W'(SSIT_DEPTH - 1));
   endfunction

   logic [N_RD-1:0][PC_W-1:0] rd_pc;
   logic [N_RD-1:0]           rd_vld;
   logic [N_RD-1:0][ID_W-1:0] rd_id;

   assign rd_pc = {look_pc, iss_pc, ins_pc, viol_load_pc, viol_store_pc};

   logic [IDX_W-1:0] vs_idx, vl_idx;
   logic             vs_vld, vl_vld;
   logic [ID_W-1:0]  vs_id, vl_id, merged_id;

   assign vs_idx = idx_of(viol_store_pc);
   assign vl_idx = idx_of(viol_load_pc);
   assign vs_vld = rd_vld[RD_VS];
   assign vl_vld = rd_vld[RD_VL];
   assign vs_id  = rd_id[RD_VS];
   assign vl_id  = rd_id[RD_VL];

   ssp_id_table #(
      .PC_W(PC_W), .DEPTH(SSIT_DEPTH), .ID_W(ID_W),
      .OFFSET_BITS(OFFSET_BITS), .N_RD(N_RD)
   ) u_id_table (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_en(viol_valid), .wr_idx_a(vs_idx), .wr_idx_b(vl_idx), .wr_id(merged_id),
      .rd_pc(rd_pc), .rd_vld(rd_vld), .rd_id(rd_id)
   );

   ssp_viol_merge #(
      .PC_W(PC_W), .DEPTH(LFST_DEPTH), .ID_W(ID_W), .HASH_SHIFT(HASH_SHIFT)
   ) u_merge (
      .store_pc(viol_store_pc),
      .s_vld(vs_vld), .s_id(vs_id),
      .l_vld(vl_vld), .l_id(vl_id),
      .merged_id(merged_id)
   );

   // Same-cycle violation is seen by insert and issue.
   logic            ins_byp, iss_byp;
   logic            ins_id_vld, iss_id_vld;
   logic [ID_W-1:0] ins_id, iss_id;

   assign ins_byp    = viol_valid && ((idx_of(ins_pc) == vs_idx) || (idx_of(ins_pc) == vl_idx));
   assign iss_byp    = viol_valid && ((idx_of(iss_pc) == vs_idx) || (idx_of(iss_pc) == vl_idx));
   assign ins_id_vld = ins_byp || rd_vld[RD_INS];
   assign iss_id_vld = iss_byp || rd_vld[RD_ISS];
   assign ins_id     = ins_byp ? merged_id : rd_id[RD_INS];
   assign iss_id     = iss_byp ? merged_id : rd_id[RD_ISS];

   logic                             lfst_ins_en, lfst_iss_en;
   logic                             lfst_rd_vld;
   logic [SEQ_W-1:0]                 lfst_rd_seq;
   logic [LFST_DEPTH-1:0]            lfst_vld;
   logic [LFST_DEPTH-1:0][SEQ_W-1:0] lfst_seq;

   assign lfst_ins_en = ins_valid && ins_id_vld && (ins_seq != '0);
   assign lfst_iss_en = iss_valid && iss_is_store && iss_id_vld;

   ssp_lfst #(
      .DEPTH(LFST_DEPTH), .ID_W(ID_W), .SEQ_W(SEQ_W)
   ) u_lfst (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ins_en(lfst_ins_en), .ins_id(ins_id), .ins_seq(ins_seq),
      .iss_en(lfst_iss_en), .iss_id(iss_id), .iss_seq(iss_seq),
      .sq_en(sq_valid), .sq_seq(sq_seq),
      .rd_id(rd_id[RD_LOOK]), .rd_vld(lfst_rd_vld), .rd_seq(lfst_rd_seq),
      .ent_vld(lfst_vld), .ent_seq(lfst_seq)
   );

   assign look_dep_seq = (rd_vld[RD_LOOK] && lfst_rd_vld) ? lfst_rd_seq : '0;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
   parameter int SEQ_W      = 16,
   parameter int ID_W       = 7,
   parameter int LFST_DEPTH = 128
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             clr,
   input logic                             viol_valid,
   input logic                             vs_vld,
   input logic [ID_W-1:0]                  vs_id,
   input logic                             vl_vld,
   input logic [ID_W-1:0]                  vl_id,
   input logic [ID_W-1:0]                  merged_id,
   input logic                             ins_valid,
   input logic [SEQ_W-1:0]                 ins_seq,
   input logic                             ins_id_vld,
   input logic [ID_W-1:0]                  ins_id,
   input logic                             iss_valid,
   input logic                             iss_is_store,
   input logic                             iss_id_vld,
   input logic [ID_W-1:0]                  iss_id,
   input logic [SEQ_W-1:0]                 iss_seq,
   input logic                             sq_valid,
   input logic [SEQ_W-1:0]                 sq_seq,
   input logic [LFST_DEPTH-1:0]            lfst_vld,
   input logic [LFST_DEPTH-1:0][SEQ_W-1:0] lfst_seq,
   input logic [SEQ_W-1:0]                 look_dep_seq
);

   AST_MERGE_LE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid && vs_vld |-> merged_id <= vs_id); // R3
   AST_MERGE_LE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid && vl_vld |-> merged_id <= vl_id); // R3
   AST_MERGE_COPY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid && vs_vld && !vl_vld |-> merged_id == vs_id); // R3
   AST_MERGE_COPY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid && !vs_vld && vl_vld |-> merged_id == vl_id); // R3

   AST_INSERT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && ins_id_vld && (ins_seq != '0) && !clr && !sq_valid && !(iss_valid && iss_is_store)
      |=> lfst_vld[$past(ins_id)] && (lfst_seq[$past(ins_id)] == $past(ins_seq))); // R5

   AST_ISSUE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && iss_is_store && iss_id_vld && !ins_valid && !clr
      && lfst_vld[iss_id] && (lfst_seq[iss_id] == iss_seq)
      |=> !lfst_vld[$past(iss_id)]); // R7

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (lfst_vld == '0) && (look_dep_seq == '0)); // R9

   for (genvar e = 0; e < LFST_DEPTH; e++) begin : g_ent_chk
      AST_NO_ZERO_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
         lfst_vld[e] |-> lfst_seq[e] != '0); // R5
      AST_SQUASH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
         sq_valid |=> !(lfst_vld[e] && (lfst_seq[e] > $past(sq_seq)))); // R8
   end

endmodule

bind store_set_predictor ssp_checker #(
   .SEQ_W(SEQ_W), .ID_W(ID_W), .LFST_DEPTH(LFST_DEPTH)
) u_ssp_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr),
   .viol_valid(viol_valid),
   .vs_vld(vs_vld), .vs_id(vs_id), .vl_vld(vl_vld), .vl_id(vl_id),
   .merged_id(merged_id),
   .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_id_vld(ins_id_vld), .ins_id(ins_id),
   .iss_valid(iss_valid), .iss_is_store(iss_is_store), .iss_id_vld(iss_id_vld),
   .iss_id(iss_id), .iss_seq(iss_seq),
   .sq_valid(sq_valid), .sq_seq(sq_seq),
   .lfst_vld(lfst_vld), .lfst_seq(lfst_seq),
   .look_dep_seq(look_dep_seq)
);

// File: tb/store_set_predictor_bench.sv
`timescale 1ns/100ps
module store_set_predictor_bench;
   localparam int PC_W = 32;
   localparam int SEQ_W = 16;
   localparam int NSSIT = 1024;
   localparam int NLFST = 128;

   // op codes
   localparam logic [3:0] OP_NOP = 4'd0, OP_VIOL = 4'd1, OP_INS = 4'd2, OP_ISS_ST = 4'd3,
                          OP_ISS_LD = 4'd4, OP_SQ = 4'd5, OP_CLR = 4'd6, OP_VIOL_INS = 4'd7;

   // {req, op, pc_a, pc_b, seq, look_pc, expected}
   localparam int NV = 23;
   localparam logic [135:0] VEC [NV] = '{
      {4'd5, OP_INS,      32'h100, 32'h0,   16'd5,  32'h100,  16'd0},  // R5 no set yet
      {4'd3, OP_VIOL,     32'h100, 32'h204, 16'd0,  32'h204,  16'd0},  // R3 fresh
      {4'd4, OP_INS,      32'h100, 32'h0,   16'd7,  32'h204,  16'd7},  // R4
      {4'd4, OP_INS,      32'h100, 32'h0,   16'd9,  32'h204,  16'd9},  // R4 newest wins
      {4'd7, OP_ISS_ST,   32'h100, 32'h0,   16'd7,  32'h204,  16'd9},  // R7 stale issue
      {4'd7, OP_ISS_LD,   32'h100, 32'h0,   16'd9,  32'h204,  16'd9},  // R7 load issue
      {4'd7, OP_ISS_ST,   32'h100, 32'h0,   16'd9,  32'h204,  16'd0},  // R7 match
      {4'd4, OP_INS,      32'h100, 32'h0,   16'd12, 32'h100,  16'd12}, // R4 store itself
      {4'd8, OP_SQ,       32'h0,   32'h0,   16'd12, 32'h204,  16'd12}, // R8 equal kept
      {4'd8, OP_SQ,       32'h0,   32'h0,   16'd11, 32'h204,  16'd0},  // R8 younger killed
      {4'd3, OP_VIOL,     32'h305, 32'h40C, 16'd0,  32'h40C,  16'd0},  // R3
      {4'd4, OP_INS,      32'h305, 32'h0,   16'd20, 32'h40C,  16'd20}, // R4
      {4'd3, OP_VIOL,     32'h100, 32'h40C, 16'd0,  32'h40C,  16'd0},  // R3 min id
      {4'd4, OP_INS,      32'h100, 32'h0,   16'd30, 32'h40C,  16'd30}, // R4
      {4'd1, OP_NOP,      32'h0,   32'h0,   16'd0,  32'h1204, 16'd30}, // R1 alias
      {4'd3, OP_VIOL,     32'h305, 32'h808, 16'd0,  32'h808,  16'd20}, // R3 load copies
      {4'd3, OP_VIOL,     32'h47C, 32'h808, 16'd0,  32'h47C,  16'd20}, // R3 store copies
      {4'd3, OP_INS,      32'h47C, 32'h0,   16'd40, 32'h305,  16'd40}, // R3 shared set
      {4'd5, OP_INS,      32'h100, 32'h0,   16'd0,  32'h204,  16'd30}, // R5 seq 0
      {4'd6, OP_VIOL_INS, 32'h9A0, 32'hC00, 16'd50, 32'hC00,  16'd50}, // R6
      {4'd2, OP_VIOL,     32'h022, 32'h060, 16'd0,  32'h060,  16'd50}, // R2 hash 0x22
      {4'd9, OP_CLR,      32'h0,   32'h0,   16'd0,  32'h060,  16'd0},  // R9
      {4'd9, OP_INS,      32'h9A0, 32'h0,   16'd60, 32'h9A0,  16'd0}   // R9 ids gone
   };

   logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
   logic viol_valid = 1'b0, ins_valid = 1'b0, iss_valid = 1'b0, iss_is_store = 1'b0, sq_valid = 1'b0;
   logic [PC_W-1:0] viol_store_pc = '0, viol_load_pc = '0, ins_pc = '0, look_pc = '0, iss_pc = '0;
   logic [SEQ_W-1:0] ins_seq = '0, iss_seq = '0, sq_seq = '0, look_dep_seq;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   store_set_predictor u_store_set_predictor (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .viol_valid(viol_valid), .viol_store_pc(viol_store_pc), .viol_load_pc(viol_load_pc),
      .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_seq(ins_seq),
      .look_pc(look_pc), .look_dep_seq(look_dep_seq),
      .iss_valid(iss_valid), .iss_is_store(iss_is_store), .iss_pc(iss_pc), .iss_seq(iss_seq),
      .sq_valid(sq_valid), .sq_seq(sq_seq)
   );

   // reference model
   bit             m_svld [NSSIT];
   logic [6:0]     m_sid  [NSSIT];
   bit             m_lvld [NLFST];
   logic [SEQ_W-1:0] m_lseq [NLFST];

   function automatic int m_idx(input logic [PC_W-1:0] pc);
      return int'((pc >> 2) & 32'h3FF);
   endfunction

   function automatic logic [6:0] m_hash(input logic [PC_W-1:0] pc);
      return 7'((pc ^ (pc >> 10)) % 32'd128);
   endfunction

   function automatic logic [SEQ_W-1:0] m_look(input logic [PC_W-1:0] pc);
      int i = m_idx(pc);
      if (m_svld[i] && m_lvld[m_sid[i]]) return m_lseq[m_sid[i]];
      return '0;
   endfunction

   task automatic m_apply();
      if (clr) begin
         for (int i = 0; i < NSSIT; i++) m_svld[i] = 1'b0;
         for (int i = 0; i < NLFST; i++) m_lvld[i] = 1'b0;
         return;
      end
      if (viol_valid) begin
         int si = m_idx(viol_store_pc);
         int li = m_idx(viol_load_pc);
         logic [6:0] id;
         if (!m_svld[si] && !m_svld[li]) id = m_hash(viol_store_pc);
         else if (m_svld[si] && !m_svld[li]) id = m_sid[si];
         else if (!m_svld[si]) id = m_sid[li];
         else id = (m_sid[si] < m_sid[li]) ? m_sid[si] : m_sid[li];
         m_svld[si] = 1'b1; m_sid[si] = id;
         m_svld[li] = 1'b1; m_sid[li] = id;
      end
      if (ins_valid && ins_seq != 0 && m_svld[m_idx(ins_pc)]) begin
         m_lvld[m_sid[m_idx(ins_pc)]] = 1'b1;
         m_lseq[m_sid[m_idx(ins_pc)]] = ins_seq;
      end
      if (iss_valid && iss_is_store && m_svld[m_idx(iss_pc)]) begin
         logic [6:0] e = m_sid[m_idx(iss_pc)];
         if (m_lvld[e] && m_lseq[e] == iss_seq) m_lvld[e] = 1'b0;
      end
      if (sq_valid)
         for (int e = 0; e < NLFST; e++)
            if (m_lvld[e] && m_lseq[e] > sq_seq) m_lvld[e] = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [SEQ_W-1:0] act, input logic [SEQ_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      clr = 1'b0; viol_valid = 1'b0; ins_valid = 1'b0; iss_valid = 1'b0;
      iss_is_store = 1'b0; sq_valid = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   function automatic logic [PC_W-1:0] rpc();
      return ((32'($urandom) % 32'd40) << 2) | ((($urandom % 3) == 0) ? 32'h1000 : 32'h0);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NSSIT; i++) begin m_svld[i] = 1'b0; m_sid[i] = '0; end
      for (int i = 0; i < NLFST; i++) begin m_lvld[i] = 1'b0; m_lseq[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: empty after reset
      look_pc = 32'h100;  #1 chk("R10 reset", look_dep_seq, 16'd0);
      look_pc = 32'h204;  #1 chk("R10 reset", look_dep_seq, 16'd0);
      look_pc = 32'h1FFC; #1 chk("R10 reset", look_dep_seq, 16'd0);

      // directed vector walk
      for (int v = 0; v < NV; v++) begin
         logic [3:0] req, op;
         logic [PC_W-1:0] a, b, lk;
         logic [SEQ_W-1:0] sq, ex;
         {req, op, a, b, sq, lk, ex} = VEC[v];
         idle();
         case (op)
            OP_VIOL:     begin viol_valid = 1'b1; viol_store_pc = a; viol_load_pc = b; end
            OP_INS:      begin ins_valid = 1'b1; ins_pc = a; ins_seq = sq; end
            OP_ISS_ST:   begin iss_valid = 1'b1; iss_is_store = 1'b1; iss_pc = a; iss_seq = sq; end
            OP_ISS_LD:   begin iss_valid = 1'b1; iss_is_store = 1'b0; iss_pc = a; iss_seq = sq; end
            OP_SQ:       begin sq_valid = 1'b1; sq_seq = sq; end
            OP_CLR:      clr = 1'b1;
            OP_VIOL_INS: begin
               viol_valid = 1'b1; viol_store_pc = a; viol_load_pc = b;
               ins_valid = 1'b1; ins_pc = a; ins_seq = sq;
            end
            default: ;
         endcase
         @(posedge clk);
         @(negedge clk);
         idle();
         look_pc = lk;
         #1 chk($sformatf("R%0d vector %0d", req, v), look_dep_seq, ex);
      end

      // model-compare phase, starting from an empty predictor (R4 overall)
      clr = 1'b1;
      @(posedge clk);
      for (int i = 0; i < NSSIT; i++) m_svld[i] = 1'b0;
      for (int i = 0; i < NLFST; i++) m_lvld[i] = 1'b0;
      begin
         logic [SEQ_W-1:0] seq_ctr = 16'd100;
         for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            clr           = (($urandom % 100) == 0);
            viol_valid    = (($urandom % 100) < 15);
            viol_store_pc = rpc();
            viol_load_pc  = rpc();
            ins_valid     = (($urandom % 100) < 40);
            ins_pc        = rpc();
            if (ins_valid) seq_ctr = seq_ctr + 16'd1;
            ins_seq       = (($urandom % 20) == 0) ? 16'd0 : seq_ctr;
            iss_valid     = (($urandom % 100) < 25);
            iss_is_store  = 1'($urandom % 2);
            iss_pc        = rpc();
            iss_seq       = seq_ctr - 16'($urandom % 4);
            sq_valid      = (($urandom % 100) < 5);
            sq_seq        = seq_ctr - 16'($urandom % 6);
            look_pc       = rpc();
            #1 chk("R4 model lookup", look_dep_seq, m_look(look_pc));
            m_apply();
         end
         @(negedge clk);
         idle();
         for (int k = 0; k < 8; k++) begin
            look_pc = rpc();
            #1 chk("R4 model final", look_dep_seq, m_look(look_pc));
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule